// File: doc/BRIEF.md
# Interrupt and DMA Request Controller

This block keeps the event flags of a serial bus controller and turns them into one interrupt line and two DMA request lines. The transfer engine reports events as one-cycle set pulses on a flag vector. Software reaches the flags, the interrupt enable mask and the two DMA enables through a small register port with four word slots.

The interrupt line is high whenever an enabled flag is pending. Each DMA request mirrors its direction's ready flag while DMA is enabled for that direction. Turning DMA on for a direction also removes that direction's ready flag from the interrupt mask. A vector slot lets an interrupt handler take one source per read. The read returns the number of the lowest pending enabled source and clears only that flag.

Register port: `reg_addr` picks a slot. Slot 0 is status, slot 1 is the enable mask, slot 2 is DMA control and slot 3 is the vector. A read is requested with `reg_rd`. The data appears on `reg_rdata` after the next rising edge and is held until the next read.

Top module: `irqdma_top`

## Requirements
- R1: After reset `irq`, `rx_dma_req` and `tx_dma_req` are low, and the status, enable and DMA-control slots all read 0.
- R2: `irq` is high exactly when some flag in status bits 5..0 is set and the enable bit at the same position is also set.
- R3: `rx_dma_req` equals status bit 3 while DMA-control bit 15 is set, and is low otherwise. `tx_dma_req` equals status bit 4 while DMA-control bit 7 is set, and is low otherwise.
- R4: A read of slot 3 returns 1 plus the position of the lowest set bit of (status bits 5..0 AND enable). If there is none, it returns 0. The same read clears that one status bit and no other.
- R5: A write to slot 0 clears the status bits that are set both in the written value and in 0x0027 (bits 0, 1, 2, 5). No other bit is affected by this write, including the ready flags at bits 3 and 4.
- R6: A write to slot 1 stores only bits 5..0. The slot reads back with all higher bits zero.
- R7: A write to slot 2 stores only bits 15 and 7, and the slot reads back those bits. If the written value has bit 15 set, enable bit 3 is cleared. If it has bit 7 set, enable bit 4 is cleared.
- R8: A read of slot 0 returns the stored status with the `bus_busy` input at bit 12.
- R9: If a set pulse and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Only status bits 1, 2, 3, 4, 9, 10, 11 and 15 can be stored. Set pulses on any other position are ignored, and those bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Slot select (0 status, 1 enable, 2 DMA control, 3 vector) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered on the edge of a read |
| set_in | input | 16 | One-cycle set pulses from the transfer engine, one per status bit |
| bus_busy | input | 1 | Bus busy level, shown at status bit 12 |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach from the ports is a pending ready flag that is later cleared while DMA is switched off and then on again. The only way to clear a ready flag is a vector read, and enabling DMA removes that flag from the mask, so the vector read would not report it. The bench therefore enables DMA first and re-arms the enable bit with a later mask write. A vector read then clears the flag, and the bench checks that the request stays low when DMA is switched back on. A second case that needs precise timing is a set pulse and a status write landing on the same edge. The bench drives both from the same falling edge.

// File: rtl/irqdma_pkg.sv
package irqdma_pkg;

    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 2;
    localparam int SRC_W        = 6;
    localparam int RX_RDY_POS   = 3;
    localparam int TX_RDY_POS   = 4;
    localparam int BUSY_POS     = 12;
    localparam int RX_DMA_POS   = 15;
    localparam int TX_DMA_POS   = 7;
    localparam logic [DATA_W-1:0] W1C_MASK  = 16'h0027;
    localparam logic [DATA_W-1:0] IMPL_MASK = 16'h8E1E;

    typedef enum logic [ADDR_W-1:0] {
        SLOT_STATUS = 2'd0,
        SLOT_ENABLE = 2'd1,
        SLOT_DMACTL = 2'd2,
        SLOT_VECTOR = 2'd3
    } slot_e;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
    } dma_cfg_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        slot_e             slot;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic int vec_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/irqdma_status.sv
module irqdma_status
    import irqdma_pkg::*;
#(
    parameter int                DW   = DATA_W,
    parameter logic [DW-1:0]     IMPL = IMPL_MASK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_in,
    input  logic [DW-1:0] clr_in,
    output logic [DW-1:0] stat_q
);

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (IMPL[i]) begin : g_flop
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (set_in[i])
                    bit_q <= 1'b1;
                else if (clr_in[i])
                    bit_q <= 1'b0;
            end
            assign stat_q[i] = bit_q;
        end else begin : g_none
            assign stat_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irqdma_cfg.sv
module irqdma_cfg
    import irqdma_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SRC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_wr,
    input  logic          dma_wr,
    input  logic [DW-1:0] wdata,
    output logic [SW-1:0] mask_q,
    output dma_cfg_t      dma_q
);

    logic [SW-1:0] mask_d;
    dma_cfg_t      dma_d;

    always_comb begin
        mask_d = mask_q;
        dma_d  = dma_q;
        if (en_wr)
            mask_d = wdata[SW-1:0];
        if (dma_wr) begin
            dma_d.rx_en = wdata[RX_DMA_POS];
            dma_d.tx_en = wdata[TX_DMA_POS];
            if (wdata[RX_DMA_POS])
                mask_d[RX_RDY_POS] = 1'b0;
            if (wdata[TX_DMA_POS])
                mask_d[TX_RDY_POS] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            dma_q  <= '0;
        end else begin
            mask_q <= mask_d;
            dma_q  <= dma_d;
        end
    end

endmodule

// File: rtl/irqdma_prio.sv
module irqdma_prio #(
    parameter int SW = 6,
    parameter int VW = 3
) (
    input  logic [SW-1:0] pend,
    output logic [VW-1:0] vec,
    output logic [SW-1:0] hit
);

    always_comb begin
        vec = '0;
        hit = '0;
        for (int i = SW - 1; i >= 0; i--) begin
            if (pend[i]) begin
                vec    = VW'(i + 1);
                hit    = '0;
                hit[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqdma_top.sv
module irqdma_top
    import irqdma_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int SW = SRC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] set_in,
    input  logic          bus_busy,
    output logic          irq,
    output logic          rx_dma_req,
    output logic          tx_dma_req
);

    localparam int VW = vec_width(SW);

    bus_req_t      req;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] clr;
    logic [SW-1:0] mask_q;
    dma_cfg_t      dma_q;
    logic [SW-1:0] pend;
    logic [SW-1:0] hit;
    logic [VW-1:0] vec;
    logic [DW-1:0] rd_mux;

    assign req.wr   = reg_wr;
    assign req.rd   = reg_rd;
    assign req.slot = slot_e'(reg_addr);
    assign req.data = reg_wdata;

    assign pend = stat_q[SW-1:0] & mask_q;

    irqdma_prio #(.SW(SW), .VW(VW)) u_prio (
        .pend (pend),
        .vec  (vec),
        .hit  (hit)
    );

    always_comb begin
        clr = '0;
        if (req.wr && req.slot == SLOT_STATUS)
            clr = req.data & W1C_MASK;
        if (req.rd && req.slot == SLOT_VECTOR)
            clr[SW-1:0] = clr[SW-1:0] | hit;
    end

    irqdma_status #(.DW(DW), .IMPL(IMPL_MASK)) u_status (
        .clk    (clk),
        .rst    (rst),
        .set_in (set_in),
        .clr_in (clr),
        .stat_q (stat_q)
    );

    irqdma_cfg #(.DW(DW), .SW(SW)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .en_wr  (req.wr && req.slot == SLOT_ENABLE),
        .dma_wr (req.wr && req.slot == SLOT_DMACTL),
        .wdata  (req.data),
        .mask_q (mask_q),
        .dma_q  (dma_q)
    );

    always_comb begin
        rd_mux = '0;
        unique case (req.slot)
            SLOT_STATUS: begin
                rd_mux           = stat_q;
                rd_mux[BUSY_POS] = bus_busy;
            end
            SLOT_ENABLE: rd_mux[SW-1:0] = mask_q;
            SLOT_DMACTL: begin
                rd_mux[RX_DMA_POS] = dma_q.rx_en;
                rd_mux[TX_DMA_POS] = dma_q.tx_en;
            end
            SLOT_VECTOR: rd_mux[VW-1:0] = vec;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (req.rd)
            reg_rdata <= rd_mux;
    end

    assign irq        = |pend;
    assign rx_dma_req = dma_q.rx_en & stat_q[RX_RDY_POS];
    assign tx_dma_req = dma_q.tx_en & stat_q[TX_RDY_POS];

endmodule

// File: rtl/irqdma_checker.sv
module irqdma_checker
    import irqdma_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int SW = SRC_W
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [DW-1:0] set_in,
    input logic          bus_busy,
    input logic          rx_dma_req,
    input logic          tx_dma_req,
    input logic [DW-1:0] stat_q,
    input logic [SW-1:0] mask_q
);

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        (|(set_in & IMPL_MASK)) |=> ((stat_q & $past(set_in & IMPL_MASK)) == $past(set_in & IMPL_MASK))); // R9

    AST_RDY_KEPT: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_rd && reg_addr == AW'(SLOT_STATUS)) |=>
        ((stat_q[TX_RDY_POS:RX_RDY_POS] & $past(stat_q[TX_RDY_POS:RX_RDY_POS])) == $past(stat_q[TX_RDY_POS:RX_RDY_POS]))); // R5

    AST_RX_REQ_SRC: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> stat_q[RX_RDY_POS]); // R3

    AST_TX_REQ_SRC: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> stat_q[TX_RDY_POS]); // R3

    AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == AW'(SLOT_VECTOR) && (stat_q[SW-1:0] & mask_q) == '0) |=> (reg_rdata == '0)); // R4

    AST_DMA_MASKS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == AW'(SLOT_DMACTL) && reg_wdata[RX_DMA_POS]) |=> !mask_q[RX_RDY_POS]); // R7

    AST_BUSY_SHOWN: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == AW'(SLOT_STATUS)) |=> (reg_rdata[BUSY_POS] == $past(bus_busy))); // R8

endmodule

bind irqdma_top irqdma_checker #(.DW(DW), .AW(AW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .set_in     (set_in),
    .bus_busy   (bus_busy),
    .rx_dma_req (rx_dma_req),
    .tx_dma_req (tx_dma_req),
    .stat_q     (stat_q),
    .mask_q     (mask_q)
);

// File: tb/tb_irqdma_top.sv
module tb_irqdma_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [15:0] set_in = 16'd0;
    logic        bus_busy = 1'b0;
    logic        irq, rx_dma_req, tx_dma_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irqdma_top dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .set_in(set_in), .bus_busy(bus_busy), .irq(irq),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] p);
        @(negedge clk); set_in = p;
        @(negedge clk); set_in = 16'd0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 rx_dma", {15'd0, rx_dma_req}, 16'd0);
        check("R1 tx_dma", {15'd0, tx_dma_req}, 16'd0);
        rd(2'd0, d); check("R1 status", d, 16'h0000);
        rd(2'd1, d); check("R1 enable", d, 16'h0000);
        rd(2'd2, d); check("R1 dmactl", d, 16'h0000);
    endtask

    task automatic t_irq_w1c();
        logic [15:0] d;
        do_reset();
        pulse(16'h0002);
        check("R2 masked flag", {15'd0, irq}, 16'd0);
        wr(2'd1, 16'h0002);
        check("R2 enabled flag", {15'd0, irq}, 16'd1);
        wr(2'd0, 16'h0002);
        check("R2 after clear", {15'd0, irq}, 16'd0);
        pulse(16'h061E);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, d); check("R5 w1c keeps ready", d, 16'h0618);
    endtask

    task automatic t_impl_bits();
        logic [15:0] d;
        do_reset();
        pulse(16'h71E1);
        rd(2'd0, d); check("R10 unimplemented ignored", d, 16'h0000);
        pulse(16'hFFFF);
        rd(2'd0, d); check("R10 implemented set", d, 16'h8E1E);
    endtask

    task automatic t_enable();
        logic [15:0] d;
        do_reset();
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); check("R6 enable width", d, 16'h003F);
    endtask

    task automatic t_dma();
        logic [15:0] d;
        do_reset();
        wr(2'd1, 16'h003F);
        pulse(16'h0008);
        check("R3 rx off", {15'd0, rx_dma_req}, 16'd0);
        check("R2 rx ready irq", {15'd0, irq}, 16'd1);
        wr(2'd2, 16'h8000);
        rd(2'd1, d); check("R7 rx dma masks bit3", d, 16'h0037);
        check("R3 rx on", {15'd0, rx_dma_req}, 16'd1);
        pulse(16'h0010);
        check("R3 tx off", {15'd0, tx_dma_req}, 16'd0);
        wr(2'd2, 16'h8080);
        rd(2'd1, d); check("R7 tx dma masks bit4", d, 16'h0027);
        check("R3 tx on", {15'd0, tx_dma_req}, 16'd1);
        wr(2'd2, 16'hFFFF);
        rd(2'd2, d); check("R7 dmactl width", d, 16'h8080);
        wr(2'd2, 16'h0000);
        check("R3 rx disabled", {15'd0, rx_dma_req}, 16'd0);
        check("R3 tx disabled", {15'd0, tx_dma_req}, 16'd0);
        wr(2'd1, 16'h0008);
        rd(2'd3, d); check("R4 vector rx ready", d, 16'd4);
        wr(2'd2, 16'h8000);
        check("R3 rx after clear", {15'd0, rx_dma_req}, 16'd0);
    endtask

    task automatic t_vector();
        logic [15:0] d;
        do_reset();
        wr(2'd1, 16'h003C);
        pulse(16'h0016);
        rd(2'd3, d); check("R4 lowest enabled", d, 16'd3);
        rd(2'd0, d); check("R4 one bit cleared", d, 16'h0012);
        check("R2 irq still pending", {15'd0, irq}, 16'd1);
        rd(2'd3, d); check("R4 next source", d, 16'd5);
        check("R2 irq idle", {15'd0, irq}, 16'd0);
        rd(2'd3, d); check("R4 none pending", d, 16'd0);
        rd(2'd0, d); check("R4 masked untouched", d, 16'h0002);
    endtask

    task automatic t_busy();
        logic [15:0] d;
        do_reset();
        bus_busy = 1'b1;
        rd(2'd0, d); check("R8 busy high", d, 16'h1000);
        bus_busy = 1'b0;
        rd(2'd0, d); check("R8 busy low", d, 16'h0000);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        do_reset();
        wr(2'd1, 16'h0002);
        @(negedge clk);
        set_in = 16'h0002; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0002;
        @(negedge clk);
        set_in = 16'h0000; reg_wr = 1'b0;
        rd(2'd0, d); check("R9 set beats clear", d, 16'h0002);
        check("R9 irq kept", {15'd0, irq}, 16'd1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_irq_w1c();
        t_impl_bits();
        t_enable();
        t_dma();
        t_vector();
        t_busy();
        t_set_wins();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule